// File: doc/BRIEF.md
# Interrupt Event and Mask Registers

This block collects completion and error strobes from a serial-bus link controller and presents them to the host as one interrupt line. Each strobe sets a sticky bit in an event register. Software reads that register and clears bits through a clear alias. A mask register with the same layout picks which events may raise the interrupt. A master-enable bit in the mask gates the whole mask. The interrupt output is a registered, active-low level.

Two positions behave differently from the plain sticky bits. A self-ID completion strobe normally sets bit 16. If bit 16 is already 1, the strobe instead sets a second sticky bit at position 15, so a second completion is not lost. The isochronous summary bits (6 for transmit, 7 for receive) cannot be written. Each one is the OR of per-context pending inputs.

The register interface is a single-cycle select/write bus with a combinational read. Address map: 0 = event read, 1 = event set alias, 2 = event clear alias, 4 = mask read, 5 = mask set alias, 6 = mask clear alias.

Top module: `irq_event_agg`

## Requirements
- R1: After reset, the event and mask registers are all zero and irq_n is 1.
- R2: Reading address 0, 1 or 2 returns the event view. Reading address 4, 5 or 6 returns the mask. Other addresses read 0. Bits 10–14 and 19–30 always read 0.
- R3: A 1 on hw_pulse at a sticky position (0–5, 8, 9, 17, 18) sets that event bit at the next edge. The bit stays 1 until software clears it.
- R4: Writing a 1 to a bit at the set alias (1 or 5) sets that bit. Writing a 1 at the clear alias (2 or 6) clears it. Writing a 0 bit changes nothing.
- R5: When a hardware strobe and a software clear hit the same event bit in the same cycle, the bit ends up at 1.
- R6: A strobe on hw_pulse[16] sets bit 16 if bit 16 is 0, and sets bit 15 if bit 16 is already 1. Inputs hw_pulse[15] and hw_pulse[6], hw_pulse[7] have no effect.
- R7: Event bit 6 reads as the OR of iso_tx_pend, and bit 7 reads as the OR of iso_rx_pend. Software writes to these two bits of the event register have no effect.
- R8: The mask register's writable bits are every event bit position (0–9, 15–18) plus the master enable at bit 31.
- R9: While mask bit 31 is 1, irq_n goes to 0 one cycle after some position other than 31 has both its event-view bit and its mask bit at 1. Otherwise irq_n goes back to 1 one cycle later.
- R10: While mask bit 31 is 0, irq_n is 1 one cycle later, whatever the other mask and event bits hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational from bus_addr) |
| hw_pulse | input | 32 | Hardware event strobes, one per event bit position |
| iso_tx_pend | input | NUM_ISO_TX | Per-context isochronous transmit pending |
| iso_rx_pend | input | NUM_ISO_RX | Per-context isochronous receive pending |
| irq_n | output | 1 | Registered active-low interrupt |

## Verification
A wrong sticky bit or a wrong mask bit shows up at bus_rdata on the very next read of that register. It shows up on irq_n one edge after the mismatch starts, as long as the mask enables that position. A strobe that goes to the wrong self-ID bit, or a lost set-versus-clear collision, appears as a single wrong bit in the next event read. Isochronous summary errors are visible in the same cycle that the pending inputs change, because the read path is combinational.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
   localparam int REG_W = 32;

   localparam int BIT_SID2   = 15;
   localparam int BIT_SID    = 16;
   localparam int BIT_ISO_TX = 6;
   localparam int BIT_ISO_RX = 7;
   localparam int BIT_MASTER = 31;

   localparam logic [REG_W-1:0] STICKY_BITS = 32'h0007_833F;
   localparam logic [REG_W-1:0] ISO_BITS    = 32'h0000_00C0;
   localparam logic [REG_W-1:0] MASTER_BIT  = 32'h8000_0000;
   localparam logic [REG_W-1:0] MASK_WR     = STICKY_BITS | ISO_BITS | MASTER_BIT;
   localparam logic [REG_W-1:0] RESERVED    = ~MASK_WR;

   typedef enum logic [2:0] {
      A_EVT     = 3'd0,
      A_EVT_SET = 3'd1,
      A_EVT_CLR = 3'd2,
      A_MSK     = 3'd4,
      A_MSK_SET = 3'd5,
      A_MSK_CLR = 3'd6
   } reg_addr_e;
endpackage

// File: rtl/irq_sticky_bank.sv
module irq_sticky_bank
   import irq_agg_pkg::*;
#(
   parameter int W = REG_W
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] sw_set,
   input  logic [W-1:0] sw_clr,
   input  logic [W-1:0] hw_pulse,
   output logic [W-1:0] evt_q
);
   localparam logic [W-1:0] SID_PAIR = (W'(1) << BIT_SID) | (W'(1) << BIT_SID2);

   logic [W-1:0] hw_eff;
   logic [W-1:0] q;

   always_comb begin
      hw_eff           = hw_pulse & W'(STICKY_BITS) & ~SID_PAIR;
      hw_eff[BIT_SID]  = hw_pulse[BIT_SID] & ~q[BIT_SID];
      hw_eff[BIT_SID2] = hw_pulse[BIT_SID] &  q[BIT_SID];
   end

   for (genvar i = 0; i < W; i++) begin : g_bit
      if (STICKY_BITS[i]) begin : g_flop
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q[i] <= 1'b0;
            else        q[i] <= (q[i] & ~sw_clr[i]) | sw_set[i] | hw_eff[i];
         end
      end else begin : g_zero
         assign q[i] = 1'b0;
      end
   end

   assign evt_q = q;
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg
   import irq_agg_pkg::*;
#(
   parameter int W = REG_W
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] sw_set,
   input  logic [W-1:0] sw_clr,
   output logic [W-1:0] msk_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) msk_q <= '0;
      else        msk_q <= ((msk_q & ~sw_clr) | sw_set) & W'(MASK_WR);
   end
endmodule

// File: rtl/irq_iso_summary.sv
module irq_iso_summary #(
   parameter int N = 4
) (
   input  logic [N-1:0] pend,
   output logic         any
);
   if (N == 1) begin : g_single
      assign any = pend[0];
   end else begin : g_reduce
      assign any = |pend;
   end
endmodule

// File: rtl/irq_out_gen.sv
module irq_out_gen
   import irq_agg_pkg::*;
#(
   parameter int W = REG_W
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] evt_view,
   input  logic [W-1:0] msk,
   output logic         irq_n
);
   logic hit;
   assign hit = msk[BIT_MASTER] & |(evt_view & msk & ~W'(MASTER_BIT));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_n <= 1'b1;
      else        irq_n <= ~hit;
   end
endmodule

// File: rtl/irq_event_agg.sv
module irq_event_agg
   import irq_agg_pkg::*;
#(
   parameter int DATA_W     = 32,
   parameter int ADDR_W     = 3,
   parameter int NUM_ISO_TX = 4,
   parameter int NUM_ISO_RX = 4
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  bus_sel,
   input  logic                  bus_wr,
   input  logic [ADDR_W-1:0]     bus_addr,
   input  logic [DATA_W-1:0]     bus_wdata,
   output logic [DATA_W-1:0]     bus_rdata,
   input  logic [DATA_W-1:0]     hw_pulse,
   input  logic [NUM_ISO_TX-1:0] iso_tx_pend,
   input  logic [NUM_ISO_RX-1:0] iso_rx_pend,
   output logic                  irq_n
);
   if (DATA_W != REG_W) begin : g_bad_width
      $error("irq_event_agg: DATA_W must equal the 32-bit register layout");
   end
   if (ADDR_W < 3) begin : g_bad_addr
      $error("irq_event_agg: ADDR_W must be at least 3");
   end
   if (NUM_ISO_TX < 1 || NUM_ISO_RX < 1) begin : g_bad_iso
      $error("irq_event_agg: at least one isochronous context per direction");
   end

   localparam logic [ADDR_W-1:0] AD_EVT     = ADDR_W'(A_EVT);
   localparam logic [ADDR_W-1:0] AD_EVT_SET = ADDR_W'(A_EVT_SET);
   localparam logic [ADDR_W-1:0] AD_EVT_CLR = ADDR_W'(A_EVT_CLR);
   localparam logic [ADDR_W-1:0] AD_MSK     = ADDR_W'(A_MSK);
   localparam logic [ADDR_W-1:0] AD_MSK_SET = ADDR_W'(A_MSK_SET);
   localparam logic [ADDR_W-1:0] AD_MSK_CLR = ADDR_W'(A_MSK_CLR);

   logic              wr_en;
   logic [DATA_W-1:0] ev_set, ev_clr, mk_set, mk_clr;
   logic [DATA_W-1:0] evt_q, msk_q, evt_view;
   logic              tx_any, rx_any;

   assign wr_en  = bus_sel & bus_wr;
   assign ev_set = (wr_en && bus_addr == AD_EVT_SET) ? bus_wdata : '0;
   assign ev_clr = (wr_en && bus_addr == AD_EVT_CLR) ? bus_wdata : '0;
   assign mk_set = (wr_en && bus_addr == AD_MSK_SET) ? bus_wdata : '0;
   assign mk_clr = (wr_en && bus_addr == AD_MSK_CLR) ? bus_wdata : '0;

   irq_sticky_bank #(.W(DATA_W)) u_bank (
      .clk(clk), .rst_n(rst_n), .sw_set(ev_set), .sw_clr(ev_clr),
      .hw_pulse(hw_pulse), .evt_q(evt_q)
   );

   irq_mask_reg #(.W(DATA_W)) u_mask (
      .clk(clk), .rst_n(rst_n), .sw_set(mk_set), .sw_clr(mk_clr), .msk_q(msk_q)
   );

   irq_iso_summary #(.N(NUM_ISO_TX)) u_iso_tx (.pend(iso_tx_pend), .any(tx_any));
   irq_iso_summary #(.N(NUM_ISO_RX)) u_iso_rx (.pend(iso_rx_pend), .any(rx_any));

   always_comb begin
      evt_view             = evt_q;
      evt_view[BIT_ISO_TX] = tx_any;
      evt_view[BIT_ISO_RX] = rx_any;
   end

   always_comb begin
      case (bus_addr)
         AD_EVT, AD_EVT_SET, AD_EVT_CLR: bus_rdata = evt_view;
         AD_MSK, AD_MSK_SET, AD_MSK_CLR: bus_rdata = msk_q;
         default:                        bus_rdata = '0;
      endcase
   end

   irq_out_gen #(.W(DATA_W)) u_out (
      .clk(clk), .rst_n(rst_n), .evt_view(evt_view), .msk(msk_q), .irq_n(irq_n)
   );
endmodule

// File: rtl/irq_event_agg_chk.sv
module irq_event_agg_chk
   import irq_agg_pkg::*;
#(
   parameter int DATA_W     = 32,
   parameter int ADDR_W     = 3,
   parameter int NUM_ISO_TX = 4
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  bus_sel,
   input logic                  bus_wr,
   input logic [ADDR_W-1:0]     bus_addr,
   input logic [DATA_W-1:0]     bus_wdata,
   input logic [DATA_W-1:0]     bus_rdata,
   input logic [DATA_W-1:0]     hw_pulse,
   input logic [NUM_ISO_TX-1:0] iso_tx_pend,
   input logic [DATA_W-1:0]     evt_q,
   input logic [DATA_W-1:0]     msk_q,
   input logic [DATA_W-1:0]     evt_view,
   input logic                  irq_n
);
   logic clr_wr, set_wr, rd_evt;
   assign clr_wr = bus_sel && bus_wr && bus_addr == ADDR_W'(A_EVT_CLR);
   assign set_wr = bus_sel && bus_wr && bus_addr == ADDR_W'(A_EVT_SET);
   assign rd_evt = bus_sel && !bus_wr && bus_addr == ADDR_W'(A_EVT);

   p_reserved_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rdata & DATA_W'(RESERVED)) == '0);

   p_hw_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
      hw_pulse[0] |=> evt_q[0]);

   p_sticky_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_q[17] && !(clr_wr && bus_wdata[17])) |=> evt_q[17]);

   p_set_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (hw_pulse[1] && clr_wr && bus_wdata[1]) |=> evt_q[1]);

   p_sid_second_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (hw_pulse[BIT_SID] && evt_q[BIT_SID]) |=> evt_q[BIT_SID2]);

   p_sid_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (hw_pulse[BIT_SID] && !evt_q[BIT_SID] && !evt_q[BIT_SID2]
       && !(set_wr && bus_wdata[BIT_SID2])) |=> !evt_q[BIT_SID2]);

   p_iso_summary_r7: assert property (@(posedge clk) disable iff (!rst_n)
      rd_evt |-> (bus_rdata[BIT_ISO_TX] == |iso_tx_pend));

   p_mask_bits_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (msk_q & DATA_W'(RESERVED)) == '0);

   p_irq_on_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (msk_q[BIT_MASTER] && |(evt_view & msk_q & ~DATA_W'(MASTER_BIT))) |=> !irq_n);

   p_master_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !msk_q[BIT_MASTER] |=> irq_n);
endmodule

bind irq_event_agg irq_event_agg_chk #(
   .DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_ISO_TX(NUM_ISO_TX)
) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
   .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
   .hw_pulse(hw_pulse), .iso_tx_pend(iso_tx_pend), .evt_q(evt_q),
   .msk_q(msk_q), .evt_view(evt_view), .irq_n(irq_n)
);

// File: tb/irq_event_agg_bench.sv
module irq_event_agg_bench;
   localparam logic [31:0] STICKY = 32'h0007_833F;
   localparam logic [31:0] MWR    = 32'h8007_83FF;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0, bus_wr = 1'b0;
   logic [2:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0, hw_pulse = '0;
   logic [3:0]  iso_tx_pend = '0, iso_rx_pend = '0;
   logic [31:0] bus_rdata;
   logic        irq_n;

   int errors = 0;
   int checks = 0;
   logic [31:0] ev_m = '0, mk_m = '0;
   logic        irq_m = 1'b1;

   always #5 clk = ~clk;

   irq_event_agg u_irq_event_agg (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .hw_pulse(hw_pulse), .iso_tx_pend(iso_tx_pend), .iso_rx_pend(iso_rx_pend),
      .irq_n(irq_n)
   );

   function automatic logic [31:0] view_f(logic [31:0] ev, logic [3:0] tx, logic [3:0] rx);
      return ev | {24'd0, |rx, |tx, 6'd0};
   endfunction

   function automatic logic [31:0] rd_f(logic [2:0] a, logic [31:0] ev, logic [31:0] mk,
                                        logic [3:0] tx, logic [3:0] rx);
      case (a)
         3'd0, 3'd1, 3'd2: return view_f(ev, tx, rx);
         3'd4, 3'd5, 3'd6: return mk;
         default:          return 32'd0;
      endcase
   endfunction

   function automatic logic [31:0] ev_next_f(logic [31:0] ev, logic s, logic w, logic [2:0] a,
                                             logic [31:0] d, logic [31:0] hw);
      logic [31:0] st, cl, he;
      st = (s && w && a == 3'd1) ? (d & STICKY) : 32'd0;
      cl = (s && w && a == 3'd2) ? d : 32'd0;
      he = hw & STICKY & ~32'h0001_8000;
      if (hw[16]) begin
         if (ev[16]) he[15] = 1'b1;
         else        he[16] = 1'b1;
      end
      return ((ev & ~cl) | st | he) & STICKY;
   endfunction

   function automatic logic [31:0] mk_next_f(logic [31:0] mk, logic s, logic w, logic [2:0] a,
                                             logic [31:0] d);
      logic [31:0] st, cl;
      st = (s && w && a == 3'd5) ? d : 32'd0;
      cl = (s && w && a == 3'd6) ? d : 32'd0;
      return ((mk & ~cl) | st) & MWR;
   endfunction

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic step(logic s, logic w, logic [2:0] a, logic [31:0] d, logic [31:0] hw,
                       logic [3:0] tx, logic [3:0] rx, string tag);
      @(negedge clk);
      check(mk_m[31] ? "R9 irq_n" : "R10 irq_n", {31'd0, irq_n}, {31'd0, irq_m});
      bus_sel = s; bus_wr = w; bus_addr = a; bus_wdata = d;
      hw_pulse = hw; iso_tx_pend = tx; iso_rx_pend = rx;
      #1;
      if (s && !w) check(tag, bus_rdata, rd_f(a, ev_m, mk_m, tx, rx));
      @(posedge clk);
      irq_m = ~(mk_m[31] & |(view_f(ev_m, tx, rx) & mk_m & ~32'h8000_0000));
      ev_m  = ev_next_f(ev_m, s, w, a, d, hw);
      mk_m  = mk_next_f(mk_m, s, w, a, d);
   endtask

   task automatic idle();
      step(1'b0, 1'b0, 3'd0, 32'd0, 32'd0, iso_tx_pend, iso_rx_pend, "R2");
   endtask

   task automatic rd(logic [2:0] a, string tag);
      step(1'b1, 1'b0, a, 32'd0, 32'd0, iso_tx_pend, iso_rx_pend, tag);
   endtask

   task automatic wr(logic [2:0] a, logic [31:0] d, logic [31:0] hw, string tag);
      step(1'b1, 1'b1, a, d, hw, iso_tx_pend, iso_rx_pend, tag);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      // R1 reset state
      check("R1 irq_n", {31'd0, irq_n}, 32'd1);
      rd(3'd0, "R1 event");
      rd(3'd4, "R1 mask");
      rd(3'd3, "R2 unused addr");
      // R3 sticky bus-reset / access-fail strobes
      step(1'b0, 1'b0, 3'd0, 32'd0, 32'h0006_0000, 4'd0, 4'd0, "R3");
      repeat (3) idle();
      rd(3'd0, "R3 sticky held");
      // R4 writing zeros changes nothing, then a one clears
      wr(3'd2, 32'd0, 32'd0, "R4");
      rd(3'd2, "R4 zero clear no effect");
      wr(3'd2, 32'h0002_0000, 32'd0, "R4");
      rd(3'd1, "R4 clear one bit");
      wr(3'd1, 32'h0000_0201, 32'd0, "R4");
      rd(3'd0, "R4 set alias");
      // R5 hardware set beats software clear
      wr(3'd2, 32'h0000_0003, 32'h0000_0002, "R5");
      rd(3'd0, "R5 set wins");
      wr(3'd2, 32'hFFFF_FFFF, 32'd0, "R4");
      // R6 self-ID chaining, and ignored strobe bits
      step(1'b0, 1'b0, 3'd0, 32'd0, 32'h0001_80C0, 4'd0, 4'd0, "R6");
      rd(3'd0, "R6 first completion");
      step(1'b0, 1'b0, 3'd0, 32'd0, 32'h0001_0000, 4'd0, 4'd0, "R6");
      rd(3'd0, "R6 second completion");
      wr(3'd2, 32'hFFFF_FFFF, 32'd0, "R4");
      // R7 isochronous summaries read-only
      wr(3'd1, 32'h0000_00C0, 32'd0, "R7");
      rd(3'd0, "R7 write ignored");
      step(1'b1, 1'b0, 3'd0, 32'd0, 32'd0, 4'b0100, 4'b0000, "R7 tx or");
      step(1'b1, 1'b0, 3'd0, 32'd0, 32'd0, 4'b0000, 4'b1000, "R7 rx or");
      wr(3'd2, 32'h0000_00C0, 32'd0, "R7");
      rd(3'd0, "R7 clear ignored");
      // R8 mask writable bits; R10 master off gates irq
      wr(3'd5, 32'h7FFF_FFFF, 32'd0, "R8");
      rd(3'd4, "R8 mask bits");
      repeat (2) idle();
      // R9 master on with pending rx summary
      wr(3'd5, 32'h8000_0000, 32'd0, "R9");
      repeat (2) idle();
      wr(3'd6, 32'h0000_0080, 32'd0, "R9");
      repeat (2) idle();
      wr(3'd6, 32'hFFFF_FFFF, 32'd0, "R8");
      rd(3'd6, "R8 mask cleared");
      // Random mixed traffic
      for (int n = 0; n < 4000; n++) begin
         logic [31:0] hw;
         hw = $urandom & $urandom & $urandom & $urandom;
         step(1'b1, ($urandom % 3) == 0, 3'($urandom % 8), $urandom, hw,
              4'($urandom & $urandom), 4'($urandom & $urandom & $urandom), "R2 random");
      end
      idle();
      @(negedge clk);
      check("R9 final irq_n", {31'd0, irq_n}, {31'd0, irq_m});
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule